// File: doc/BRIEF.md
# Synchronous Burst Static Memory with Lane Writes

This block is a single-clock static memory whose words are 18 bits wide, split into two 9-bit byte lanes, each carrying its parity bit. Every input (address, write data, chip enables, strobes and write controls) is sampled on the rising clock edge. Read data takes the flow-through path: the word addressed in a read cycle appears on the output shortly after the edge that captured the access, with no output register in between.

An access starts when either of two address strobes is low. The primary strobe wins when both are low, is honoured only while the first chip enable is active, and always starts a read. The secondary strobe starts an access that follows the write controls. After a start, a low advance input steps a 2-bit counter that produces the next three burst addresses. The counter either adds to the loaded low address bits or is XOR-ed with them, chosen by an order input that is sampled when the burst starts. Writes go to one lane, to both lanes, or to all lanes through a global write that overrides the lane controls.

Top module: `sram_burst_top`

## Requirements
- R1: While reset is low at a clock edge, the following cycle shows out_en = 0 and dout = 0.
- R2: A start with all three chip enables active loads addr, and in a read cycle dout carries the word at that address in the cycle right after the capturing edge, with out_en = 1.
- R3: When pri_strobe_n is low and en_a_n is low, the access is a read even if sec_strobe_n is also low and the write controls request a write; the array is left unchanged.
- R4: pri_strobe_n has no effect while en_a_n is high: an ongoing burst carries on as if no strobe were present.
- R5: A strobe (pri_strobe_n low with en_a_n low, or sec_strobe_n low) while any chip enable is inactive (en_a_n high, en_b low or en_c_n high) ends the burst; out_en stays 0 until a new access starts.
- R6: With order_xor = 0 at the start, each low step_n adds 1 modulo 4 to the two low address bits; the upper address bits stay fixed.
- R7: With order_xor = 1 at the start, the two low address bits are the loaded low bits XOR the step count (0,1,2,3).
- R8: In a burst with no strobe and step_n high, the address holds and the same word is read again.
- R9: With all_wr_n high and lane_gate_n low, lane_wr_n[0] low writes bits 8:0 and lane_wr_n[1] low writes bits 17:9; lanes whose bit is high keep their contents.
- R10: With all_wr_n low, both lanes are written whatever lane_gate_n and lane_wr_n are.
- R11: With all_wr_n high and lane_gate_n high, the cycle is a read and nothing is written.
- R12: out_en is 1 only after a read cycle of an active access; after a write cycle or while idle it is 0 and dout is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_a_n | input | 1 | First chip enable, active low; also gates the primary strobe |
| en_b | input | 1 | Second chip enable, active high |
| en_c_n | input | 1 | Third chip enable, active low |
| pri_strobe_n | input | 1 | Primary address strobe, active low, read-only start |
| sec_strobe_n | input | 1 | Secondary address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| order_xor | input | 1 | Burst order: 0 additive, 1 XOR; sampled at start |
| all_wr_n | input | 1 | Global write, active low |
| lane_gate_n | input | 1 | Enables the per-lane write controls, active low |
| lane_wr_n | input | 2 | Per-lane write, active low; bit 0 lane 8:0, bit 1 lane 17:9 |
| addr | input | ADDR_W | Word address loaded at start |
| din | input | 18 | Write data |
| dout | output | 18 | Flow-through read data, zero when not driven |
| out_en | output | 1 | High when dout carries read data |

## Verification
Writes land in the array at the edge that samples the write controls, and a read word is due in the cycle right after the edge that captured its access, since only the address and cycle-type registers lie between input and output. The bench therefore drives inputs between edges and samples dout and out_en two nanoseconds after each rising edge, comparing against the access that edge captured. Burst tests count one edge per address, so each expected word follows from the start address, the order and the number of low step_n edges.

// File: rtl/sram_burst_pkg.sv
// Shared widths and the burst ordering function.
// Assumes two 9-bit lanes per word (data plus parity).
package sram_burst_pkg;
    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;

    typedef enum logic { ORDER_ADD = 1'b0, ORDER_XOR = 1'b1 } order_e;

    // Low address bits for burst step cnt from loaded base bits.
    function automatic logic [1:0] burst_low(input logic [1:0] base,
                                             input logic [1:0] cnt,
                                             input order_e     ord);
        return (ord == ORDER_XOR) ? (base ^ cnt) : (base + cnt);
    endfunction
endpackage

// File: rtl/sram_burst_addr.sv
// Burst address generator: holds the loaded upper bits, the loaded low
// bits, the order and a 2-bit step count. Gives the address for the
// current cycle (registered) and the address for the coming edge.
// Assumes load and step are never both high.
module sram_burst_addr
    import sram_burst_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              order_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int UP_W = ADDR_W - 2;

    logic [UP_W-1:0] upper_q;
    logic [1:0]      base_q;
    logic [1:0]      cnt_q;
    logic [1:0]      cnt_nxt;
    order_e          order_q;

    // Count for the coming edge: cleared on load, bumped on step.
    always_comb begin
        cnt_nxt = cnt_q;
        if (load)      cnt_nxt = 2'd0;
        else if (step) cnt_nxt = cnt_q + 2'd1;
    end

    // Address the coming edge will act on.
    always_comb begin
        if (load) nxt_addr = addr_in;
        else      nxt_addr = {upper_q, burst_low(base_q, cnt_nxt, order_q)};
    end

    assign cur_addr = {upper_q, burst_low(base_q, cnt_q, order_q)};

    // Capture the start address and order, advance the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            base_q  <= 2'd0;
            cnt_q   <= 2'd0;
            order_q <= ORDER_ADD;
        end else begin
            cnt_q <= cnt_nxt;
            if (load) begin
                upper_q <= addr_in[ADDR_W-1:2];
                base_q  <= addr_in[1:0];
                order_q <= order_e'(order_in);
            end
        end
    end

    AST_ADD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && order_q == ORDER_ADD) |=>
            (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1)); // R6
    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!load) |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]))); // R6
    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(cur_addr)); // R8
endmodule

// File: rtl/sram_lane_decode.sv
// Write-lane decode: global write selects every lane, otherwise the
// lane gate passes the per-lane controls. A read-only start masks all.
module sram_lane_decode
    import sram_burst_pkg::*;
(
    input  logic             read_only,
    input  logic             all_wr_n,
    input  logic             lane_gate_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic [LANES-1:0] lane_wr
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // One write enable per lane.
        assign lane_wr[l] = !read_only &&
                            (!all_wr_n || (!lane_gate_n && !lane_wr_n[l]));
    end
endmodule

// File: rtl/sram_core.sv
// Storage array, one bank per lane so each lane is written alone.
// Write at the clock edge, read combinationally (flow-through).
module sram_core
    import sram_burst_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic [LANES-1:0]  wr_lane,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_bank
        logic [LANE_W-1:0] bank [DEPTH];

        // Lane write at the edge.
        always_ff @(posedge clk) begin
            if (wr_lane[l]) bank[waddr] <= wdata[l*LANE_W +: LANE_W];
        end

        assign rdata[l*LANE_W +: LANE_W] = bank[raddr];
    end
endmodule

// File: rtl/sram_burst_top.sv
// Synchronous burst memory top: decides each edge whether an access
// starts, continues, or the part deselects; steers the write lanes and
// the flow-through read. Assumes order_xor is steady within a burst.
module sram_burst_top
    import sram_burst_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              en_c_n,
    input  logic              pri_strobe_n,
    input  logic              sec_strobe_n,
    input  logic              step_n,
    input  logic              order_xor,
    input  logic              all_wr_n,
    input  logic              lane_gate_n,
    input  logic [1:0]        lane_wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [17:0]       din,
    output logic [17:0]       dout,
    output logic              out_en
);
    logic              sel, pri_req, start_req, load, cont, step, access;
    logic              active_q, rd_q;
    logic [LANES-1:0]  lane_dec, lane_wr;
    logic [ADDR_W-1:0] nxt_addr, cur_addr;
    logic [WORD_W-1:0] rdata;

    // Classify the edge: start, continue or deselect.
    always_comb begin
        sel       = !en_a_n && en_b && !en_c_n;
        pri_req   = !pri_strobe_n && !en_a_n;
        start_req = pri_req || !sec_strobe_n;
        load      = start_req && sel;
        cont      = !start_req && active_q;
        step      = cont && !step_n;
        access    = load || cont;
    end

    sram_lane_decode u_dec (
        .read_only   (pri_req),
        .all_wr_n    (all_wr_n),
        .lane_gate_n (lane_gate_n),
        .lane_wr_n   (lane_wr_n),
        .lane_wr     (lane_dec)
    );

    assign lane_wr = access ? lane_dec : '0;

    sram_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .order_in (order_xor),
        .addr_in  (addr),
        .nxt_addr (nxt_addr),
        .cur_addr (cur_addr)
    );

    sram_core #(.ADDR_W(ADDR_W)) u_core (
        .clk     (clk),
        .wr_lane (lane_wr),
        .waddr   (nxt_addr),
        .wdata   (din),
        .raddr   (cur_addr),
        .rdata   (rdata)
    );

    // Track burst activity and whether this cycle is a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            rd_q     <= 1'b0;
        end else begin
            active_q <= access;
            rd_q     <= access && (lane_wr == '0);
        end
    end

    assign out_en = rd_q;
    assign dout   = rd_q ? rdata : '0;

    AST_PRI_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!pri_strobe_n && !en_a_n && en_b && !en_c_n) |=> out_en); // R3
    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((!sec_strobe_n || (!pri_strobe_n && !en_a_n)) &&
         (en_a_n || !en_b || en_c_n)) |=> !out_en); // R5
    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_wr) |=> !out_en); // R12
    AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_wr_n && access && !pri_req) |-> (&lane_wr)); // R10
    AST_NO_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (all_wr_n && lane_gate_n) |-> (lane_wr == '0)); // R11
endmodule

// File: tb/sram_burst_top_tb_top.sv
module sram_burst_top_tb_top;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_a_n, en_b, en_c_n, pri_n, sec_n, step_n, ord;
    logic          gw_n, gate_n;
    logic [1:0]    lwr_n;
    logic [AW-1:0] addr;
    logic [17:0]   din;
    logic [17:0]   dout;
    logic          out_en;
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done = 0;

    localparam logic [17:0] TBL [8] = '{18'h00001, 18'h3FFFF, 18'h2AAAA,
        18'h15555, 18'h1C3A5, 18'h0F0F0, 18'h30303, 18'h12345};

    always #5 clk = ~clk;

    sram_burst_top #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_a_n(en_a_n), .en_b(en_b),
        .en_c_n(en_c_n), .pri_strobe_n(pri_n), .sec_strobe_n(sec_n),
        .step_n(step_n), .order_xor(ord), .all_wr_n(gw_n),
        .lane_gate_n(gate_n), .lane_wr_n(lwr_n), .addr(addr), .din(din),
        .dout(dout), .out_en(out_en)
    );

    task automatic chk(input string req, input logic [17:0] act,
                       input logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        en_a_n = 0; en_b = 1; en_c_n = 0; pri_n = 1; sec_n = 1;
        step_n = 1; ord = 0; gw_n = 1; gate_n = 1; lwr_n = 2'b11;
        addr = '0; din = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // Start through the secondary strobe; write controls as given.
    task automatic start_sec(input logic [AW-1:0] a, input logic [17:0] d,
                             input logic g, input logic bg,
                             input logic [1:0] lw, input logic o);
        idle();
        sec_n = 0; addr = a; din = d; gw_n = g; gate_n = bg;
        lwr_n = lw; ord = o;
        tick();
        idle();
    endtask

    task automatic read_at(input logic [AW-1:0] a, input string req,
                           input logic [17:0] exp);
        start_sec(a, '0, 1, 1, 2'b11, 0);
        chk(req, {17'd0, out_en}, 18'd1);
        chk(req, dout, exp);
    endtask

    initial begin
        idle();
        rst_n = 0;
        tick(); tick();
        // R1: reset state
        chk("R1 out_en", {17'd0, out_en}, 18'd0);
        chk("R1 dout", dout, 18'd0);
        rst_n = 1;
        tick();
        chk("R12 idle out_en", {17'd0, out_en}, 18'd0);

        // Table walk: full writes then flow-through reads.
        for (int i = 0; i < 8; i++) begin
            start_sec(AW'(32'h40 + i), TBL[i], 0, 1, 2'b11, 0);
            chk("R12 write no drive", {17'd0, out_en}, 18'd0);
        end
        for (int i = 0; i < 8; i++) read_at(AW'(32'h40 + i), "R2 R11 read", TBL[i]);

        // R6 additive burst from 0x41, then hold and ignored strobe.
        start_sec(10'h041, '0, 1, 1, 2'b11, 0);
        chk("R6 first", dout, TBL[1]);
        step_n = 0; tick(); chk("R6 step1", dout, TBL[2]);
        step_n = 0; tick(); chk("R6 step2", dout, TBL[3]);
        step_n = 0; tick(); chk("R6 wrap", dout, TBL[0]);
        step_n = 1; tick(); chk("R8 hold", dout, TBL[0]);
        chk("R8 hold en", {17'd0, out_en}, 18'd1);
        // R4: primary strobe with en_a_n high is ignored.
        en_a_n = 1; pri_n = 0; step_n = 0; addr = 10'h047; tick();
        chk("R4 burst continues", dout, TBL[1]);
        chk("R4 still reading", {17'd0, out_en}, 18'd1);
        idle();

        // R7 XOR burst from 0x45: 45,44,47,46.
        start_sec(10'h045, '0, 1, 1, 2'b11, 1);
        chk("R7 first", dout, TBL[5]);
        step_n = 0; tick(); chk("R7 step1", dout, TBL[4]);
        step_n = 0; tick(); chk("R7 step2", dout, TBL[7]);
        step_n = 0; tick(); chk("R7 step3", dout, TBL[6]);
        idle();

        // R5: strobe with en_b low ends the burst.
        sec_n = 0; en_b = 0; addr = 10'h040; tick();
        chk("R5 deselect", {17'd0, out_en}, 18'd0);
        idle(); step_n = 0; tick();
        chk("R5 stays off", {17'd0, out_en}, 18'd0);
        chk("R5 dout zero", dout, 18'd0);

        // R9 lane writes at 0x10.
        start_sec(10'h010, 18'h3FFFF, 0, 1, 2'b11, 0);
        start_sec(10'h010, 18'h00000, 1, 0, 2'b10, 0);
        read_at(10'h010, "R9 lane0", 18'h3FE00);
        start_sec(10'h010, 18'h15555, 1, 0, 2'b01, 0);
        read_at(10'h010, "R9 lane1", 18'h15400);
        // R10: global write overrides lane controls.
        start_sec(10'h010, 18'h0ABCD, 0, 0, 2'b11, 0);
        read_at(10'h010, "R10 global", 18'h0ABCD);
        // R11: lane gate high, no write even with lanes low.
        start_sec(10'h010, 18'h00000, 1, 1, 2'b00, 0);
        chk("R11 read cycle", dout, 18'h0ABCD);
        read_at(10'h010, "R11 unchanged", 18'h0ABCD);

        // R3: both strobes with a global write is a read.
        idle();
        pri_n = 0; sec_n = 0; gw_n = 0; addr = 10'h010; din = 18'h00000;
        tick();
        chk("R3 reads", {17'd0, out_en}, 18'd1);
        chk("R3 old data", dout, 18'h0ABCD);
        idle();
        read_at(10'h010, "R3 unchanged", 18'h0ABCD);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule